// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a memory-mapped watchdog that escalates in two equal steps. It compares an absolute 64-bit deadline against a free-running system counter supplied from outside. If software does not refresh in time, the block first raises an interrupt level. If the same interval then passes again with no refresh, it raises a reset level. The reset level stays set until the block itself is reset, so software can see afterwards that the watchdog caused the last restart.

There are two register frames, each on a simple select/write bus whose read data is combinational. The refresh frame holds only a refresh word and identification words. Software uses the control frame to enable or stop the timer, to set the interval length, and to read or preset the 64-bit deadline. Any write to the control word restarts the interval. A write to the refresh word or the interval word also restarts it, but only while the timer is enabled. A restart sets the deadline to the current counter value plus the interval.

Top module: `dual_stage_wdog`

## Requirements
- R1: After reset the control word reads 0 (bit 0 enable, bit 1 first-stage status, bit 2 second-stage status, all clear), and both `irqStage0` and `rstStage1` are low.
- R2: In both frames, address 0xFCC reads parameter `IFID_VALUE`. The words at 0xFD0 + 4*k (k from 0 to `ID_WORDS`-1) read `ID_SEED` + k.
- R3: A control-frame write to 0x000 sets enable from data bit 0, clears the first-stage status, and loads the deadline with counter + interval. This happens whether the write enables or disables the timer.
- R4: While enabled, with no pending first stage, the first-stage status and `irqStage0` rise on the clock edge at which counter >= deadline. On that same edge the deadline reloads to counter + interval.
- R5: While enabled, a refresh-frame write to 0x000 clears the first-stage status and loads the deadline with counter + interval.
- R6: While enabled with the first stage pending, the second-stage status and `rstStage1` rise on the edge at which counter >= deadline.
- R7: The second-stage status stays set until reset. Refreshes and control writes do not clear it.
- R8: A write to the interval word (control frame 0x008) stores the value. While enabled, it also restarts the interval using the new value. While disabled, it leaves the deadline unchanged.
- R9: The deadline can be written and read as two words, low at 0x010 and high at 0x014. The comparison uses all 64 bits.
- R10: While disabled, neither stage asserts, the deadline does not move, and refresh-frame writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sysCount | input | 64 | Free-running system counter value |
| rfSel | input | 1 | Refresh frame select |
| rfWrite | input | 1 | Refresh frame write (1) or read (0) |
| rfAddr | input | 12 | Refresh frame byte address |
| rfRdata | output | 32 | Refresh frame read data |
| cfSel | input | 1 | Control frame select |
| cfWrite | input | 1 | Control frame write (1) or read (0) |
| cfAddr | input | 12 | Control frame byte address |
| cfWdata | input | 32 | Control frame write data |
| cfRdata | output | 32 | Control frame read data |
| irqStage0 | output | 1 | First-stage interrupt level |
| rstStage1 | output | 1 | Second-stage reset level |

## Verification
The bench holds the counter at chosen values, so each deadline crossing falls on a known edge. It checks one tick below the deadline and then exactly at it. A design that compared with strict greater-than, or that did not reload the deadline when the first stage fired, would show the wrong stage or the wrong readback deadline at those points. The bench also checks that the second stage survives a refresh, and that interval and refresh writes while disabled leave the deadline alone. A design that escalated or moved the deadline while disabled would fail there. Finally, it programs the high deadline word before the low one and crosses a boundary at bit 32. A comparator that looked only at 32 bits would fire early.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  localparam logic [11:0] ADDR_REFRESH  = 12'h000;
  localparam logic [11:0] ADDR_CTRL     = 12'h000;
  localparam logic [11:0] ADDR_OFFSET   = 12'h008;
  localparam logic [11:0] ADDR_CV_LO    = 12'h010;
  localparam logic [11:0] ADDR_CV_HI    = 12'h014;
  localparam logic [11:0] ADDR_IFID     = 12'hFCC;
  localparam logic [11:0] ADDR_ID_FIRST = 12'hFD0;

  // Strobes from the register interface to the timer datapath.
  typedef struct packed {
    logic        refresh;   // refresh-frame word written
    logic        ctrlWr;    // control word written
    logic        offsetWr;  // interval word written
    logic        cvLoWr;    // deadline low word written
    logic        cvHiWr;    // deadline high word written
    logic [31:0] data;      // control-frame write data
  } wdStrobe_t;

endpackage

// File: rtl/wdog_regif.sv
module wdog_regif
  import wdog_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 32,
  parameter int          COUNT_W    = 64,
  parameter logic [31:0] IFID_VALUE = 32'h0A55_0001,
  parameter logic [7:0]  ID_SEED    = 8'h40,
  parameter int          ID_WORDS   = 12
) (
  input  logic                rfSel,
  input  logic                rfWrite,
  input  logic [ADDR_W-1:0]   rfAddr,
  output logic [DATA_W-1:0]   rfRdata,
  input  logic                cfSel,
  input  logic                cfWrite,
  input  logic [ADDR_W-1:0]   cfAddr,
  input  logic [DATA_W-1:0]   cfWdata,
  output logic [DATA_W-1:0]   cfRdata,
  input  logic                en,
  input  logic                ws0,
  input  logic                ws1,
  input  logic [DATA_W-1:0]   offset,
  input  logic [COUNT_W-1:0]  compare,
  output wdStrobe_t           stb
);

  localparam int HI_W = COUNT_W - DATA_W;

  logic [DATA_W-1:0] idTable [ID_WORDS];
  logic [ADDR_W-1:0] idAddr  [ID_WORDS];

  genvar gi;
  generate
    for (gi = 0; gi < ID_WORDS; gi++) begin : g_id
      assign idTable[gi] = DATA_W'(ID_SEED) + DATA_W'(gi);
      assign idAddr[gi]  = ADDR_W'(int'(ADDR_ID_FIRST) + 4 * gi);
    end
  endgenerate

  logic [DATA_W-1:0] idRdRf, idRdCf;

  always_comb begin
    idRdRf = '0;
    idRdCf = '0;
    if (rfAddr == ADDR_W'(ADDR_IFID)) idRdRf = DATA_W'(IFID_VALUE);
    if (cfAddr == ADDR_W'(ADDR_IFID)) idRdCf = DATA_W'(IFID_VALUE);
    for (int i = 0; i < ID_WORDS; i++) begin
      if (rfAddr == idAddr[i]) idRdRf = idTable[i];
      if (cfAddr == idAddr[i]) idRdCf = idTable[i];
    end
  end

  logic rfWr, cfWr;
  assign rfWr = rfSel && rfWrite;
  assign cfWr = cfSel && cfWrite;

  always_comb begin
    stb          = '0;
    stb.data     = 32'(cfWdata);
    stb.refresh  = rfWr && (rfAddr == ADDR_W'(ADDR_REFRESH));
    stb.ctrlWr   = cfWr && (cfAddr == ADDR_W'(ADDR_CTRL));
    stb.offsetWr = cfWr && (cfAddr == ADDR_W'(ADDR_OFFSET));
    stb.cvLoWr   = cfWr && (cfAddr == ADDR_W'(ADDR_CV_LO));
    stb.cvHiWr   = cfWr && (cfAddr == ADDR_W'(ADDR_CV_HI));
  end

  always_comb begin
    rfRdata = '0;
    if (rfSel && !rfWrite) rfRdata = idRdRf;
  end

  always_comb begin
    cfRdata = '0;
    if (cfSel && !cfWrite) begin
      if (cfAddr == ADDR_W'(ADDR_CTRL))        cfRdata = DATA_W'({ws1, ws0, en});
      else if (cfAddr == ADDR_W'(ADDR_OFFSET)) cfRdata = offset;
      else if (cfAddr == ADDR_W'(ADDR_CV_LO))  cfRdata = compare[DATA_W-1:0];
      else if (cfAddr == ADDR_W'(ADDR_CV_HI))  cfRdata = DATA_W'(compare[DATA_W +: HI_W]);
      else                                     cfRdata = idRdCf;
    end
  end

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COUNT_W-1:0] sysCount,
  input  wdStrobe_t          stb,
  output logic               en,
  output logic               ws0,
  output logic               ws1,
  output logic [DATA_W-1:0]  offset,
  output logic [COUNT_W-1:0] compare
);

  localparam int HI_W = COUNT_W - DATA_W;

  logic              due;
  logic              doRefresh;
  logic              cvWrite;
  logic [DATA_W-1:0] offsetNext;
  logic [COUNT_W-1:0] reloadVal;

  assign due        = sysCount >= compare;
  assign doRefresh  = stb.ctrlWr || (en && (stb.refresh || stb.offsetWr));
  assign cvWrite    = stb.cvLoWr || stb.cvHiWr;
  assign offsetNext = stb.offsetWr ? DATA_W'(stb.data) : offset;
  assign reloadVal  = sysCount + COUNT_W'(offsetNext);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      ws0     <= 1'b0;
      ws1     <= 1'b0;
      offset  <= '0;
      compare <= '0;
    end else begin
      if (stb.ctrlWr)   en     <= stb.data[0];
      if (stb.offsetWr) offset <= DATA_W'(stb.data);
      if (doRefresh) begin
        compare <= reloadVal;
        ws0     <= 1'b0;
      end else if (cvWrite) begin
        if (stb.cvLoWr) compare[DATA_W-1:0]    <= DATA_W'(stb.data);
        if (stb.cvHiWr) compare[DATA_W +: HI_W] <= HI_W'(stb.data);
      end else if (en && due) begin
        if (!ws0) begin
          ws0     <= 1'b1;
          compare <= reloadVal;
        end else begin
          ws1     <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog
  import wdog_pkg::*;
#(
  parameter int          ADDR_W     = 12,
  parameter int          DATA_W     = 32,
  parameter int          COUNT_W    = 64,
  parameter logic [31:0] IFID_VALUE = 32'h0A55_0001,
  parameter logic [7:0]  ID_SEED    = 8'h40,
  parameter int          ID_WORDS   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COUNT_W-1:0] sysCount,
  input  logic               rfSel,
  input  logic               rfWrite,
  input  logic [ADDR_W-1:0]  rfAddr,
  output logic [DATA_W-1:0]  rfRdata,
  input  logic               cfSel,
  input  logic               cfWrite,
  input  logic [ADDR_W-1:0]  cfAddr,
  input  logic [DATA_W-1:0]  cfWdata,
  output logic [DATA_W-1:0]  cfRdata,
  output logic               irqStage0,
  output logic               rstStage1
);

  wdStrobe_t          stb;
  logic               en, ws0, ws1;
  logic [DATA_W-1:0]  offset;
  logic [COUNT_W-1:0] compare;

  wdog_regif #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W),
    .IFID_VALUE(IFID_VALUE), .ID_SEED(ID_SEED), .ID_WORDS(ID_WORDS)
  ) u_regif (
    .rfSel(rfSel), .rfWrite(rfWrite), .rfAddr(rfAddr), .rfRdata(rfRdata),
    .cfSel(cfSel), .cfWrite(cfWrite), .cfAddr(cfAddr), .cfWdata(cfWdata),
    .cfRdata(cfRdata), .en(en), .ws0(ws0), .ws1(ws1), .offset(offset),
    .compare(compare), .stb(stb)
  );

  wdog_timer #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .sysCount(sysCount), .stb(stb),
    .en(en), .ws0(ws0), .ws1(ws1), .offset(offset), .compare(compare)
  );

  assign irqStage0 = ws0;
  assign rstStage1 = ws1;

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic [COUNT_W-1:0] sysCount,
  input logic               rfSel,
  input logic               rfWrite,
  input logic [ADDR_W-1:0]  rfAddr,
  input logic               cfSel,
  input logic               cfWrite,
  input logic [ADDR_W-1:0]  cfAddr,
  input logic [DATA_W-1:0]  cfWdata,
  input logic               irqStage0,
  input logic               rstStage1,
  input logic               en,
  input logic [DATA_W-1:0]  offset,
  input logic [COUNT_W-1:0] compare
);

  p_ctrl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfSel && cfWrite && cfAddr == '0) |=> (!irqStage0 && en == $past(cfWdata[0])));

  p_stage0_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqStage0) |-> (compare == $past(sysCount) + COUNT_W'($past(offset))));

  p_refresh_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rfSel && rfWrite && rfAddr == '0 && en) |=> !irqStage0);

  p_stage1_after_stage0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rstStage1) |-> $past(irqStage0));

  p_reset_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rstStage1 |=> rstStage1);

  p_quiet_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !irqStage0);

  p_no_escalate_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !$rose(rstStage1));

endmodule

bind dual_stage_wdog wdog_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sysCount(sysCount), .rfSel(rfSel),
  .rfWrite(rfWrite), .rfAddr(rfAddr), .cfSel(cfSel), .cfWrite(cfWrite),
  .cfAddr(cfAddr), .cfWdata(cfWdata), .irqStage0(irqStage0),
  .rstStage1(rstStage1), .en(en), .offset(offset), .compare(compare)
);

// File: tb/dual_stage_wdog_tb.sv
`timescale 1ns/1ps
module dual_stage_wdog_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sysCount = '0;
  logic        rfSel = 1'b0, rfWrite = 1'b0;
  logic [11:0] rfAddr = '0;
  logic [31:0] rfRdata;
  logic        cfSel = 1'b0, cfWrite = 1'b0;
  logic [11:0] cfAddr = '0;
  logic [31:0] cfWdata = '0;
  logic [31:0] cfRdata;
  logic        irqStage0, rstStage1;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dual_stage_wdog u_dut (
    .clk(clk), .rst_n(rst_n), .sysCount(sysCount),
    .rfSel(rfSel), .rfWrite(rfWrite), .rfAddr(rfAddr), .rfRdata(rfRdata),
    .cfSel(cfSel), .cfWrite(cfWrite), .cfAddr(cfAddr), .cfWdata(cfWdata),
    .cfRdata(cfRdata), .irqStage0(irqStage0), .rstStage1(rstStage1)
  );

  // Scoreboard queues: kind 0 = control read, 1 = refresh read, 2 = irq, 3 = reset out
  int          kindQ[$];
  logic [31:0] expQ[$];
  string       tagQ[$];
  event        sampleEv;

  initial begin
    forever begin
      @(sampleEv);
      while (kindQ.size() > 0) begin
        int          k;
        logic [31:0] e, a;
        string       t;
        k = kindQ.pop_front();
        e = expQ.pop_front();
        t = tagQ.pop_front();
        case (k)
          0: a = cfRdata;
          1: a = rfRdata;
          2: a = {31'b0, irqStage0};
          default: a = {31'b0, rstStage1};
        endcase
        total++;
        if (a !== e) begin
          bad++;
          $display("FAIL %s actual=0x%0h expected=0x%0h", t, a, e);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [11:0] addr,
                             input logic [31:0] exp, input string tag);
    @(negedge clk);
    if (kind == 0) begin cfSel = 1'b1; cfWrite = 1'b0; cfAddr = addr; end
    if (kind == 1) begin rfSel = 1'b1; rfWrite = 1'b0; rfAddr = addr; end
    kindQ.push_back(kind);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    #1 -> sampleEv;
    #0.5;
    cfSel = 1'b0;
    rfSel = 1'b0;
  endtask

  task automatic cf_write(input logic [11:0] addr, input logic [31:0] data);
    @(negedge clk);
    cfSel = 1'b1; cfWrite = 1'b1; cfAddr = addr; cfWdata = data;
    @(negedge clk);
    cfSel = 1'b0; cfWrite = 1'b0;
  endtask

  task automatic rf_write(input logic [11:0] addr);
    @(negedge clk);
    rfSel = 1'b1; rfWrite = 1'b1; rfAddr = addr;
    @(negedge clk);
    rfSel = 1'b0; rfWrite = 1'b0;
  endtask

  task automatic set_count(input logic [63:0] v);
    @(negedge clk);
    sysCount = v;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    expect_item(0, 12'h000, 32'h0, "R1 ctrl after reset");
    expect_item(2, 12'h0, 32'h0, "R1 irq after reset");
    expect_item(3, 12'h0, 32'h0, "R1 rst after reset");

    // R2 identification
    expect_item(0, 12'hFCC, 32'h0A55_0001, "R2 ctrl frame ifid");
    expect_item(1, 12'hFCC, 32'h0A55_0001, "R2 refresh frame ifid");
    expect_item(0, 12'hFD4, 32'h41, "R2 ctrl frame id word 1");
    expect_item(1, 12'hFFC, 32'h4B, "R2 refresh frame id word 11");

    // R8 / R10: interval write while disabled does not move deadline, no stage
    set_count(64'd1000);
    cf_write(12'h008, 32'd50);
    expect_item(0, 12'h008, 32'd50, "R8 interval stored");
    expect_item(0, 12'h010, 32'd0, "R8 disabled interval write keeps deadline");
    expect_item(2, 12'h0, 32'h0, "R10 disabled no stage0 past deadline");

    // R3 enable via control write
    cf_write(12'h000, 32'h1);
    expect_item(0, 12'h000, 32'h1, "R3 enabled ctrl read");
    expect_item(0, 12'h010, 32'd1050, "R3 deadline low after enable");
    expect_item(0, 12'h014, 32'd0, "R3 deadline high after enable");

    // R4 first stage on reaching deadline
    set_count(64'd1049);
    expect_item(2, 12'h0, 32'h0, "R4 no stage0 one tick early");
    set_count(64'd1050);
    expect_item(2, 12'h0, 32'h1, "R4 stage0 at deadline");
    expect_item(0, 12'h000, 32'h3, "R4 ctrl shows stage0");
    expect_item(0, 12'h010, 32'd1100, "R4 deadline reloaded");

    // R5 refresh clears stage0
    set_count(64'd1060);
    rf_write(12'h000);
    expect_item(2, 12'h0, 32'h0, "R5 refresh clears stage0");
    expect_item(0, 12'h010, 32'd1110, "R5 refresh reloads deadline");

    // R6 second stage
    set_count(64'd1110);
    expect_item(2, 12'h0, 32'h1, "R6 stage0 before escalation");
    expect_item(0, 12'h010, 32'd1160, "R6 second interval deadline");
    set_count(64'd1159);
    expect_item(3, 12'h0, 32'h0, "R6 no stage1 one tick early");
    set_count(64'd1160);
    expect_item(3, 12'h0, 32'h1, "R6 stage1 at second deadline");
    expect_item(0, 12'h000, 32'h7, "R6 ctrl shows both stages");

    // R7 stage1 sticky across refresh
    rf_write(12'h000);
    expect_item(0, 12'h000, 32'h5, "R7 stage1 kept after refresh");
    expect_item(3, 12'h0, 32'h1, "R7 reset output kept");

    // R8 interval write while enabled restarts with new value
    cf_write(12'h008, 32'd30);
    expect_item(0, 12'h010, 32'd1190, "R8 enabled interval write reloads");

    // R9 64-bit deadline, high word first
    cf_write(12'h014, 32'h1);
    cf_write(12'h010, 32'h10);
    expect_item(0, 12'h014, 32'h1, "R9 deadline high readback");
    expect_item(0, 12'h010, 32'h10, "R9 deadline low readback");
    set_count(64'h0000_0001_0000_000F);
    expect_item(2, 12'h0, 32'h0, "R9 no fire below 64-bit deadline");
    set_count(64'h0000_0001_0000_0010);
    expect_item(2, 12'h0, 32'h1, "R9 fire at 64-bit deadline");

    // R3 disabling write clears stage0; R10 frozen while disabled
    cf_write(12'h000, 32'h0);
    expect_item(2, 12'h0, 32'h0, "R3 disable clears stage0");
    expect_item(0, 12'h000, 32'h4, "R3 ctrl after disable");
    expect_item(0, 12'h010, 32'h2E, "R3 disable write reloads deadline");
    rf_write(12'h000);
    set_count(64'h0000_0002_0000_0000);
    expect_item(0, 12'h010, 32'h2E, "R10 disabled refresh and counter ignored");
    expect_item(2, 12'h0, 32'h0, "R10 disabled no stage0");
    cf_write(12'h008, 32'd99);
    expect_item(0, 12'h010, 32'h2E, "R8 disabled interval write ignored");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule